// File: doc/BRIEF.md
# Double-Buffered Converter Code Interface

This block accepts a 14-bit converter code from a host and holds it in two stages: a staging register that the host writes, and an output register that drives the converter code. The host writes the staging register either over a 14-bit parallel bus using a select and a write strobe, or over a three-wire serial link that reuses three of those bus pins. A separate active-low load strobe then copies the staging register into the output register. The output therefore changes only when the host asks for it, whichever interface wrote the new value.

A static mode strap chooses the interface. In serial mode the write strobe acts as a frame sync. Two further bus pins select the bit order and the placement of the 14 code bits within a 16-clock frame. All host pins are asynchronous. They pass through two-flop synchronizers, and their edges are detected on the system clock.

Top module: `dual_stage_dac_if`

## Requirements
- R1: After reset, the output code `dac_code_o` is midscale 0x2000, and the staging register also holds 0x2000.
- R2: In parallel mode (`ser_mode_i`=0), a rising edge of `wr_ni` while `cs_ni` is low stores `bus_i` into the staging register. `dac_code_o` does not change as a result.
- R3: In parallel mode, a write strobe while `cs_ni` is high leaves the staging register unchanged.
- R4: A falling edge of `ldac_ni` copies the staging register to `dac_code_o`. `dac_code_o` changes at no other time.
- R5: In serial mode (`ser_mode_i`=1), `wr_ni` is the frame sync, `bus_i[13]` is serial data and `bus_i[12]` is the serial clock. Bits are taken on falling serial-clock edges only while sync is low and after sync has fallen. The staging register is written when the 16th bit of the frame arrives.
- R6: `bus_i[11]`, sampled when sync falls, sets the bit order. A 1 means the first valid bit is code bit 13 (MSB). A 0 means the first valid bit is code bit 0 (LSB).
- R7: `bus_i[10]`, sampled when sync falls, sets the justification. A 1 means the valid bits are frame bits 3 to 16. A 0 means they are frame bits 1 to 14. The two remaining frame bits are discarded.
- R8: A frame in which sync rises before the 16th clock leaves the staging register unchanged. Clocks after the 16th within one frame are ignored.
- R9: The load strobe works independently of the write path. A load during an open serial frame transfers the previously stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_mode_i | input | 1 | Mode strap: 1 serial, 0 parallel |
| cs_ni | input | 1 | Active-low parallel select |
| wr_ni | input | 1 | Parallel write strobe / serial frame sync |
| ldac_ni | input | 1 | Active-low load strobe, acts on its falling edge |
| bus_i | input | 14 | Parallel code; in serial mode [13] data, [12] clock, [11] order, [10] justification |
| dac_code_o | output | 14 | Code driving the converter |

## Verification
The assertions assume that the mode strap is static while frames and writes are in flight. They also assume that each host pin holds its level for several system clocks around any edge. In particular, the serial clock is at most a quarter of the system clock rate, and the order and justification pins are stable before sync falls. The bench keeps each serial clock phase at four system cycles. It changes data only while the serial clock is high, and it holds the bus and select for several cycles on both sides of every write and load edge.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int CODE_W    = 14;
  localparam int FRAME_LEN = 16;
  localparam int SPARE_N   = FRAME_LEN - CODE_W;
  localparam int SYNC_STG  = 2;
  // serial role of shared bus pins
  localparam int SDATA_BIT = CODE_W - 1;
  localparam int SCLK_BIT  = CODE_W - 2;
  localparam int ORDER_BIT = CODE_W - 3;
  localparam int JUST_BIT  = CODE_W - 4;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t MIDSCALE = code_t'(1) << (CODE_W - 1);
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/par_capture.sv
module par_capture
  import dac_if_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  cs_n_i,
  input  logic  wr_n_i,
  input  code_t bus_i,
  output logic  we_o,
  output code_t data_o
);
  logic  wr_prev, cs_prev;
  code_t bus_prev;

  // select and data taken one cycle back to tolerate zero hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev  <= 1'b1;
      cs_prev  <= 1'b1;
      bus_prev <= '0;
    end else begin
      wr_prev  <= wr_n_i;
      cs_prev  <= cs_n_i;
      bus_prev <= bus_i;
    end
  end

  assign we_o   = en_i && wr_n_i && !wr_prev && !cs_prev;
  assign data_o = bus_prev;

  p_wr_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $rose(wr_n_i));
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import dac_if_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  sync_n_i,
  input  logic  sclk_i,
  input  logic  sdata_i,
  input  logic  order_i,
  input  logic  just_i,
  output logic  we_o,
  output code_t data_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] SKIP  = CNT_W'(SPARE_N);
  localparam logic [CNT_W-1:0] TAKEN = CNT_W'(CODE_W);

  logic             sync_prev, sclk_prev;
  logic             active, msb_first, right_just;
  logic [CNT_W-1:0] cnt;
  code_t            sr, sr_nxt;
  logic             sync_fall, sclk_fall, bit_valid, take;

  assign sync_fall = en_i && sync_prev && !sync_n_i;
  assign sclk_fall = sclk_prev && !sclk_i;
  assign bit_valid = right_just ? (cnt >= SKIP) : (cnt < TAKEN);
  assign take      = active && !sync_n_i && sclk_fall && (cnt < FULL);
  assign sr_nxt    = msb_first ? {sr[CODE_W-2:0], sdata_i} : {sdata_i, sr[CODE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev  <= 1'b1;
      sclk_prev  <= 1'b1;
      active     <= 1'b0;
      msb_first  <= 1'b1;
      right_just <= 1'b1;
      cnt        <= '0;
      sr         <= '0;
    end else begin
      sync_prev <= sync_n_i;
      sclk_prev <= sclk_i;
      if (sync_fall) begin
        active     <= 1'b1;
        msb_first  <= order_i;
        right_just <= just_i;
        cnt        <= '0;
        sr         <= '0;
      end else if (sync_n_i || !en_i) begin
        active <= 1'b0;
      end else if (take) begin
        cnt <= cnt + 1'b1;
        if (bit_valid) sr <= sr_nxt;
      end
    end
  end

  assign we_o   = take && (cnt == LAST);
  assign data_o = bit_valid ? sr_nxt : sr;

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= FULL);
  p_commit_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (!we_o && cnt == FULL));
endmodule

// File: rtl/dual_stage_dac_if.sv
module dual_stage_dac_if
  import dac_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_i,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              ldac_ni,
  input  logic [CODE_W-1:0] bus_i,
  output logic [CODE_W-1:0] dac_code_o
);
  logic       mode_q;
  logic [2:0] ctl_q;
  code_t      bus_q;
  logic       cs_q, wr_q, ld_q, ld_prev, ld_fall;
  logic       par_we, ser_we;
  code_t      par_data, ser_data, in_latch, out_latch;

  pin_sync #(.W(1), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_mode_sync (
    .clk_i, .rst_ni, .d_i(ser_mode_i), .q_o(mode_q));
  pin_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_ctl_sync (
    .clk_i, .rst_ni, .d_i({ldac_ni, wr_ni, cs_ni}), .q_o(ctl_q));
  pin_sync #(.W(CODE_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_bus_sync (
    .clk_i, .rst_ni, .d_i(bus_i), .q_o(bus_q));

  assign {ld_q, wr_q, cs_q} = ctl_q;

  par_capture u_par (
    .clk_i, .rst_ni, .en_i(!mode_q), .cs_n_i(cs_q), .wr_n_i(wr_q),
    .bus_i(bus_q), .we_o(par_we), .data_o(par_data));

  ser_shift u_ser (
    .clk_i, .rst_ni, .en_i(mode_q), .sync_n_i(wr_q),
    .sclk_i(bus_q[SCLK_BIT]), .sdata_i(bus_q[SDATA_BIT]),
    .order_i(bus_q[ORDER_BIT]), .just_i(bus_q[JUST_BIT]),
    .we_o(ser_we), .data_o(ser_data));

  assign ld_fall = ld_prev && !ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_prev   <= 1'b1;
      in_latch  <= MIDSCALE;
      out_latch <= MIDSCALE;
    end else begin
      ld_prev <= ld_q;
      if (par_we)      in_latch <= par_data;
      else if (ser_we) in_latch <= ser_data;
      if (ld_fall) out_latch <= in_latch;
    end
  end

  assign dac_code_o = out_latch;

  p_in_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(par_we || ser_we) |=> $stable(in_latch));
  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_fall |=> $stable(dac_code_o));
  p_one_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({par_we, ser_we}));
endmodule

// File: tb/tb_dual_stage_dac_if.sv
module tb_dual_stage_dac_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_mode = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1;
  logic [13:0] bus = '0;
  logic [13:0] dac_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_stage_dac_if dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_mode_i(ser_mode), .cs_ni(cs_n),
    .wr_ni(wr_n), .ldac_ni(ldac_n), .bus_i(bus), .dac_code_o(dac_code));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic par_write(input logic [13:0] v, input logic sel_n);
    cs_n = sel_n; bus = v; cyc(3);
    wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(3);
    cs_n = 1'b1; cyc(6);
  endtask

  task automatic load();
    ldac_n = 1'b0; cyc(4);
    ldac_n = 1'b1; cyc(6);
  endtask

  // time-ordered frame bits computed from the R6/R7 definitions
  task automatic ser_frame(input logic [13:0] code, input logic msb, input logic rj,
                           input int nbits, input bit mid_load);
    bus[11] = msb; bus[10] = rj; bus[12] = 1'b1; cyc(4);
    wr_n = 1'b0; cyc(4);
    for (int t = 0; t < nbits; t++) begin
      int k;
      k = rj ? t - 2 : t;
      if (t < 16 && k >= 0 && k < 14) bus[13] = msb ? code[13-k] : code[k];
      else bus[13] = 1'b1;
      cyc(4);
      bus[12] = 1'b0; cyc(4);
      bus[12] = 1'b1;
      if (mid_load && t == 7) load();
    end
    cyc(4);
    wr_n = 1'b1; cyc(6);
  endtask

  task automatic t_reset();
    check("R1 reset output", dac_code, 14'h2000);
    load();
    check("R1 reset staging", dac_code, 14'h2000);
  endtask

  task automatic t_parallel();
    par_write(14'h1A5B, 1'b0);
    check("R2 no output change before load", dac_code, 14'h2000);
    load();
    check("R2/R4 parallel value loaded", dac_code, 14'h1A5B);
    par_write(14'h3FFF, 1'b0);
    par_write(14'h0001, 1'b0);
    load();
    check("R2 last write wins", dac_code, 14'h0001);
  endtask

  task automatic t_cs_gate();
    par_write(14'h2222, 1'b1);
    load();
    check("R3 deselected write ignored", dac_code, 14'h0001);
  endtask

  task automatic t_load_only();
    par_write(14'h0F0F, 1'b0);
    cyc(20);
    check("R4 output holds without load", dac_code, 14'h0001);
    load();
    check("R4 load transfers", dac_code, 14'h0F0F);
    load();
    check("R4 repeated load same value", dac_code, 14'h0F0F);
  endtask

  task automatic t_serial_modes();
    ser_mode = 1'b1; cyc(6);
    ser_frame(14'h2A5C, 1'b1, 1'b1, 16, 0); load();
    check("R5/R6/R7 msb-first right-justified", dac_code, 14'h2A5C);
    ser_frame(14'h1337, 1'b0, 1'b1, 16, 0); load();
    check("R6 lsb-first right-justified", dac_code, 14'h1337);
    ser_frame(14'h3FFE, 1'b1, 1'b0, 16, 0); load();
    check("R7 msb-first left-justified", dac_code, 14'h3FFE);
    ser_frame(14'h0C81, 1'b0, 1'b0, 16, 0); load();
    check("R7 lsb-first left-justified", dac_code, 14'h0C81);
  endtask

  task automatic t_serial_frame_edges();
    ser_frame(14'h1111, 1'b1, 1'b1, 10, 0); load();
    check("R8 aborted frame ignored", dac_code, 14'h0C81);
    ser_frame(14'h05A0, 1'b1, 1'b0, 20, 0); load();
    check("R8 extra clocks ignored", dac_code, 14'h05A0);
  endtask

  task automatic t_load_mid_frame();
    ser_frame(14'h3333, 1'b1, 1'b1, 16, 1);
    check("R9 mid-frame load takes old value", dac_code, 14'h05A0);
    load();
    check("R9 later load takes new frame", dac_code, 14'h3333);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_parallel();
    t_cs_gate();
    t_load_only();
    bus = 14'h1000;
    cyc(6);
    t_serial_modes();
    t_serial_frame_edges();
    t_load_mid_frame();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule